// File: doc/BRIEF.md
# Loss-of-Lock Hysteresis Monitor

This block turns a stream of frequency-error measurements, each a signed ppm figure delivered with a one-cycle valid strobe, into a loss-of-lock indication for a clock recovery loop. The thresholds are asymmetric. A locked loop is declared lost only when the error magnitude goes beyond 1000 ppm. A lost loop is declared locked again only once the magnitude has come back to 250 ppm or less. Between those bounds the current state is kept. Two measurement sources are wired in: oscillator against incoming data, and divided oscillator against divided reference. A control bit chooses which one is used, and both sources use the same thresholds.

Whenever the live indication goes from locked to lost, the block emits a one-cycle acquisition-restart pulse. While the loop is locked, it holds a fine-loop enable high. A sticky status bit records that at least one loss has happened. That bit is cleared only by writing the clear control bit to 1 and then back to 0. A second control bit places the sticky bit, instead of the live state, on the registered external indicator. Control writes arrive as a simple strobe carrying a 3-bit word.

Top module: `lol_hyst_monitor`

## Requirements
- R1: After a synchronous reset, `lol_live` and `lol_out` are 1, `sticky_status`, `acq_start` and `fine_loop_en` are 0, and all control bits are 0.
- R2: While `lol_live` is 0, a selected valid sample whose magnitude is greater than 1000 ppm sets `lol_live` at that clock edge. A magnitude of exactly 1000 does not set it.
- R3: While `lol_live` is 1, a selected valid sample whose magnitude is 250 ppm or less clears `lol_live` at that edge. A magnitude of 251 does not clear it.
- R4: A sample whose magnitude lies between the two thresholds leaves `lol_live` unchanged. So does any cycle with no selected valid sample.
- R5: The error is a signed 16-bit two's-complement value, and only its magnitude is compared. The value -32768 counts as magnitude 32768.
- R6: Control bit 0 (`ref_sel`) chooses the source. At 0 the data-path sample is used, and at 1 the reference-path sample is used. A strobe on the source that is not selected has no effect.
- R7: `acq_start` pulses high for exactly the one cycle that follows a 0-to-1 transition of `lol_live`. `fine_loop_en` always equals the inverse of `lol_live`.
- R8: `sticky_status` is set by every 0-to-1 transition of `lol_live`. It stays set after lock is regained.
- R9: Control bit 2 (`sticky_clr`) clears `sticky_status` only when it is written to 0 while it holds 1. Writing 0 when it is already 0 does not clear the bit, and neither does writing 1.
- R10: If a loss event coincides with the clearing write, `sticky_status` ends up set.
- R11: `lol_out` is registered. One cycle after an edge, it shows the value that `sticky_status` held before that edge if control bit 1 (`static_en`) was 1 before the edge. Otherwise it shows the value `lol_live` held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_err_valid | input | 1 | Strobe for a data-versus-oscillator sample |
| data_err_ppm | input | 16 | Signed data-path error, ppm |
| ref_err_valid | input | 1 | Strobe for a reference-versus-oscillator sample |
| ref_err_ppm | input | 16 | Signed reference-path error, ppm |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 3 | Control word: bit0 ref_sel, bit1 static_en, bit2 sticky_clr |
| lol_out | output | 1 | Registered external indicator, live or sticky |
| lol_live | output | 1 | Live hysteresis state |
| acq_start | output | 1 | One-cycle acquisition restart pulse |
| fine_loop_en | output | 1 | Fine phase loop enable, high while locked |
| sticky_status | output | 1 | Sticky loss-of-lock status |

## Verification
On every cycle, the embedded assertions check four things: the threshold transitions and the hold behaviour of the hysteresis state; that the restart pulse goes with each rise of the state; that the sticky bit is retained and that a set wins over a clear; and the one-cycle relation of the output multiplexer. Only the bench scenarios can show the exact boundary values (1000 against 1001, 250 against 251, and -32768), the effect of switching sources, and the full write-1-then-0 clear sequence, including the writes that must not clear. A random phase then compares every output, cycle by cycle, with a bench model.

// File: rtl/lol_mon_pkg.sv
package lol_mon_pkg;
  localparam int CTRL_W = 3;
  typedef struct packed {
    logic sticky_clr;
    logic static_en;
    logic ref_sel;
  } ctrl_t;
endpackage

// File: rtl/lol_err_select.sv
module lol_err_select #(
  parameter int ERR_W = 16,
  localparam int MAG_W = ERR_W + 1
) (
  input  logic             ref_sel,
  input  logic             data_valid,
  input  logic [ERR_W-1:0] data_err,
  input  logic             ref_valid,
  input  logic [ERR_W-1:0] ref_err,
  output logic             sel_valid,
  output logic [MAG_W-1:0] sel_mag
);
  logic [ERR_W-1:0] picked;

  function automatic logic [MAG_W-1:0] mag_of(input logic [ERR_W-1:0] v);
    logic [MAG_W-1:0] ext;
    ext = {v[ERR_W-1], v};
    return v[ERR_W-1] ? (~ext + 1'b1) : ext;
  endfunction

  always_comb begin
    sel_valid = ref_sel ? ref_valid : data_valid;
    picked    = ref_sel ? ref_err   : data_err;
    sel_mag   = mag_of(picked);
  end
endmodule

// File: rtl/lol_hyst_fsm.sv
module lol_hyst_fsm #(
  parameter int MAG_W  = 17,
  parameter int HI_PPM = 1000,
  parameter int LO_PPM = 250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_valid,
  input  logic [MAG_W-1:0] sel_mag,
  output logic             lol_q,
  output logic             acq_q,
  output logic             loss_event
);
  localparam logic [MAG_W-1:0] HI_T = MAG_W'(HI_PPM);
  localparam logic [MAG_W-1:0] LO_T = MAG_W'(LO_PPM);

  logic above_hi, within_lo;

  always_comb begin
    above_hi   = sel_mag > HI_T;
    within_lo  = sel_mag <= LO_T;
    loss_event = sel_valid && !lol_q && above_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lol_q <= 1'b1;
      acq_q <= 1'b0;
    end else begin
      acq_q <= loss_event;
      if (sel_valid) begin
        if (lol_q && within_lo)
          lol_q <= 1'b0;
        else if (!lol_q && above_hi)
          lol_q <= 1'b1;
      end
    end
  end

  assert_set_above_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && !lol_q && sel_mag > HI_T) |=> lol_q);
  assert_clear_within_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && lol_q && sel_mag <= LO_T) |=> !lol_q);
  assert_hold_no_sample_R4: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |=> $stable(lol_q));
  assert_acq_with_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lol_q) |-> acq_q);
endmodule

// File: rtl/lol_ctrl_regs.sv
module lol_ctrl_regs
  import lol_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic              clear_req
);
  ctrl_t wr_word;

  always_comb begin
    wr_word   = ctrl_t'(wdata);
    clear_req = wr && ctrl_q.sticky_clr && !wr_word.sticky_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr) ctrl_q <= wr_word;
  end
endmodule

// File: rtl/lol_sticky.sv
module lol_sticky (
  input  logic clk,
  input  logic rst,
  input  logic loss_event,
  input  logic clear_req,
  output logic sticky_q
);
  always_ff @(posedge clk) begin
    if (rst)             sticky_q <= 1'b0;
    else if (loss_event) sticky_q <= 1'b1;
    else if (clear_req)  sticky_q <= 1'b0;
  end

  assert_sticky_retained_R8: assert property (@(posedge clk) disable iff (rst)
    (sticky_q && !clear_req) |=> sticky_q);
  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
    loss_event |=> sticky_q);
endmodule

// File: rtl/lol_hyst_monitor.sv
module lol_hyst_monitor
  import lol_mon_pkg::*;
#(
  parameter int ERR_W  = 16,
  parameter int HI_PPM = 1000,
  parameter int LO_PPM = 250,
  localparam int MAG_W = ERR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_err_valid,
  input  logic [ERR_W-1:0]  data_err_ppm,
  input  logic              ref_err_valid,
  input  logic [ERR_W-1:0]  ref_err_ppm,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic              lol_out,
  output logic              lol_live,
  output logic              acq_start,
  output logic              fine_loop_en,
  output logic              sticky_status
);
  ctrl_t            ctrl_q;
  logic             clear_req, sel_valid, loss_event, out_q, past_ok;
  logic [MAG_W-1:0] sel_mag;

  lol_ctrl_regs u_ctrl (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .clear_req(clear_req)
  );

  lol_err_select #(.ERR_W(ERR_W)) u_sel (
    .ref_sel(ctrl_q.ref_sel),
    .data_valid(data_err_valid), .data_err(data_err_ppm),
    .ref_valid(ref_err_valid),   .ref_err(ref_err_ppm),
    .sel_valid(sel_valid), .sel_mag(sel_mag)
  );

  lol_hyst_fsm #(.MAG_W(MAG_W), .HI_PPM(HI_PPM), .LO_PPM(LO_PPM)) u_fsm (
    .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_mag(sel_mag),
    .lol_q(lol_live), .acq_q(acq_start), .loss_event(loss_event)
  );

  lol_sticky u_sticky (
    .clk(clk), .rst(rst), .loss_event(loss_event),
    .clear_req(clear_req), .sticky_q(sticky_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 1'b1;
      past_ok <= 1'b0;
    end else begin
      out_q   <= ctrl_q.static_en ? sticky_status : lol_live;
      past_ok <= 1'b1;
    end
  end

  assign lol_out      = out_q;
  assign fine_loop_en = !lol_live;

  assert_out_mux_R11: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (lol_out == ($past(ctrl_q.static_en) ? $past(sticky_status) : $past(lol_live))));
  assert_fine_en_R7: assert property (@(posedge clk) disable iff (rst)
    fine_loop_en != lol_live);
endmodule

// File: tb/lol_hyst_monitor_tb.sv
module lol_hyst_monitor_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dv = 1'b0, rv = 1'b0, wr = 1'b0;
  logic [15:0] de = '0, re = '0;
  logic [2:0] wd = '0;
  logic o_out, o_live, o_acq, o_fine, o_sticky;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic m_live = 1'b1, m_sticky = 1'b0, m_out = 1'b1, m_acq = 1'b0;
  logic [2:0] m_cfg = '0;

  always #2.5 clk = ~clk;

  lol_hyst_monitor dut_i (
    .clk(clk), .rst(rst),
    .data_err_valid(dv), .data_err_ppm(de),
    .ref_err_valid(rv), .ref_err_ppm(re),
    .ctrl_wr(wr), .ctrl_wdata(wd),
    .lol_out(o_out), .lol_live(o_live), .acq_start(o_acq),
    .fine_loop_en(o_fine), .sticky_status(o_sticky)
  );

  function automatic int mag16(input logic [15:0] v);
    return v[15] ? (65536 - int'(v)) : int'(v);
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "lol_live", o_live, m_live);
    chk(tag, "lol_out", o_out, m_out);
    chk(tag, "sticky_status", o_sticky, m_sticky);
    chk(tag, "acq_start", o_acq, m_acq);
    chk(tag, "fine_loop_en", o_fine, !m_live);
  endtask

  task automatic model_edge();
    logic sv, ev, clrp;
    logic [15:0] se;
    int mg;
    sv = m_cfg[0] ? rv : dv;
    se = m_cfg[0] ? re : de;
    mg = mag16(se);
    ev = sv && !m_live && (mg > 1000);
    clrp = wr && m_cfg[2] && !wd[2];
    m_out = m_cfg[1] ? m_sticky : m_live;
    m_acq = ev;
    m_sticky = ev ? 1'b1 : (clrp ? 1'b0 : m_sticky);
    if (sv) m_live = m_live ? !(mg <= 250) : (mg > 1000);
    if (wr) m_cfg = wd;
  endtask

  task automatic step(input logic idv, input logic [15:0] ide,
                      input logic irv, input logic [15:0] ire,
                      input logic iwr, input logic [2:0] iwd, input string tag);
    dv = idv; de = ide; rv = irv; re = ire; wr = iwr; wd = iwd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk_all(tag);
    dv = 0; rv = 0; wr = 0;
  endtask

  task automatic dsamp(input int e, input string tag);
    step(1, 16'(e), 0, 16'h0, 0, 3'b0, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 16'h0, 0, 16'h0, 0, 3'b0, tag);
  endtask

  task automatic cwr(input logic [2:0] w, input string tag);
    step(0, 16'h0, 0, 16'h0, 1, w, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    chk_all("R1");
    chk("R1", "lol_live reset", o_live, 1'b1);
    chk("R1", "sticky reset", o_sticky, 1'b0);

    dsamp(0, "R3");
    chk("R3", "relock at 0", o_live, 1'b0);
    dsamp(1000, "R2");
    chk("R2", "1000 holds lock", o_live, 1'b0);
    dsamp(1001, "R2");
    chk("R2", "1001 loses lock", o_live, 1'b1);
    chk("R7", "acq pulse", o_acq, 1'b1);
    chk("R8", "sticky set", o_sticky, 1'b1);
    idle("R7");
    chk("R7", "acq one cycle", o_acq, 1'b0);
    dsamp(500, "R4");
    chk("R4", "mid holds lol", o_live, 1'b1);
    dsamp(251, "R3");
    chk("R3", "251 keeps lol", o_live, 1'b1);
    dsamp(250, "R3");
    chk("R3", "250 relocks", o_live, 1'b0);
    chk("R8", "sticky kept after relock", o_sticky, 1'b1);
    dsamp(-999, "R4");
    chk("R4", "mid holds lock", o_live, 1'b0);
    dsamp(-1001, "R5");
    chk("R5", "-1001 loses lock", o_live, 1'b1);
    dsamp(-250, "R5");
    chk("R5", "-250 relocks", o_live, 1'b0);
    dsamp(-32768, "R5");
    chk("R5", "-32768 loses lock", o_live, 1'b1);
    dsamp(0, "R3");

    cwr(3'b001, "R6");
    step(1, 16'd5000, 0, 16'h0, 0, 3'b0, "R6");
    chk("R6", "data path ignored", o_live, 1'b0);
    step(0, 16'h0, 1, 16'd1001, 0, 3'b0, "R6");
    chk("R6", "ref path loses lock", o_live, 1'b1);
    step(0, 16'h0, 1, 16'd250, 0, 3'b0, "R6");
    chk("R6", "ref path relock", o_live, 1'b0);

    cwr(3'b001, "R9");
    chk("R9", "write 0 alone keeps sticky", o_sticky, 1'b1);
    cwr(3'b101, "R9");
    chk("R9", "write 1 keeps sticky", o_sticky, 1'b1);
    cwr(3'b001, "R9");
    chk("R9", "1 then 0 clears", o_sticky, 1'b0);
    idle("R9");
    chk("R9", "stays clear", o_sticky, 1'b0);
    cwr(3'b101, "R10");
    step(0, 16'h0, 1, 16'd3000, 1, 3'b001, "R10");
    chk("R10", "set wins over clear", o_sticky, 1'b1);
    step(0, 16'h0, 1, 16'd10, 0, 3'b0, "R10");

    cwr(3'b011, "R11");
    idle("R11");
    chk("R11", "out shows sticky", o_out, 1'b1);
    chk("R11", "live relocked", o_live, 1'b0);
    cwr(3'b111, "R11");
    cwr(3'b011, "R11");
    idle("R11");
    chk("R11", "out follows cleared sticky", o_out, 1'b0);
    cwr(3'b000, "R11");
    step(1, 16'd2000, 0, 16'h0, 0, 3'b0, "R11");
    idle("R11");
    chk("R11", "out shows live", o_out, 1'b1);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [15:0] e;
      k = $urandom_range(0, 5);
      case (k)
        0: e = 16'($urandom_range(0, 250));
        1: e = 16'($urandom_range(251, 1000));
        2: e = 16'($urandom_range(1001, 40000));
        3: e = 16'(-$urandom_range(0, 300));
        4: e = 16'(-$urandom_range(900, 1100));
        default: e = 16'($urandom);
      endcase
      step($urandom_range(0, 2) != 0, e, $urandom_range(0, 2) != 0, 16'($urandom_range(0, 1200)),
           $urandom_range(0, 5) == 0, 3'($urandom), "R11");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule